// File: doc/BRIEF.md
# Boot-Mode Address Alias Decoder

This block sits on a processor's address bus in front of three memory targets: application flash, a system boot ROM and SRAM. Every address is decoded on its upper bits and the request is steered to exactly one target. The target sees only its low offset bits, so each memory behaves as if it were based at zero. A single 32-bit control word at a fixed address holds the current low-window mapping.

The first 64 KiB of the address space is a low alias window. It mirrors one of the three targets, so the processor can fetch its initial stack pointer and reset vector from address zero. Two strap pins choose the mirrored target, and they are captured while reset is held. Software can later rewrite the mapping through the control word, for example to place an SRAM vector table at zero without a reset. Each target stays reachable at its own home base at all times.

Decoding is combinational. The response (valid, data, error) is registered and appears one cycle after the request. Addresses that hit no region give an error with zero data.

Top module: `boot_alias_decoder`

## Requirements
- R1: Flash is reachable at its home range 0x0800_0000 to 0x0803_FFFF whatever the mapping. A read there selects flash with offset equal to address bits [17:0].
- R2: Boot ROM answers at 0x1FFF_0000 to 0x1FFF_7FFF with offset bits [14:0]. SRAM answers at 0x2000_0000 to 0x2001_FFFF with offset bits [16:0]. Both are reachable under every mapping.
- R3: A mapping code decides the target of addresses 0x0000_0000 to 0x0000_FFFF. Codes 2'b00 and 2'b10 select flash, 2'b01 selects boot ROM and 2'b11 selects SRAM. The offset sent is the address itself.
- R4: The words at alias addresses 0 and 4 equal the words read at the selected target's base+0 and base+4.
- R5: An alias-window access beyond the mirrored target's size is an error. The same holds for any address from 0x0001_0000 up that falls in no region. Example: 0x9000 with boot ROM (32 KiB) mirrored.
- R6: An unmapped access asserts no target select. One cycle later it gives err_o=1 with rdata_o=0 for that single response.
- R7: The mapping code is loaded from strap_i only while reset is in effect. Strap changes after reset release do not change the mapping.
- R8: The control word at 0x4000_0000 reads back the mapping code in bits [1:0], with zeros above. A write loads wdata_i[1:0] into the mapping, and the very next transaction uses the new mapping. Any other address near it (e.g. 0x4000_0004) is unmapped.
- R9: rvalid_o is high exactly in the cycle after a cycle with req_i high. At most one target select is high at any time.
- R10: Writes to SRAM pass through with sram_we_o high and are read back afterwards. A write that decodes to flash or boot ROM asserts no select and returns err_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Boot strap pins, captured during reset |
| req_i | input | 1 | Transaction request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address from the processor |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Response valid, one cycle after request |
| rdata_o | output | 32 | Read data (zero on error or write) |
| err_o | output | 1 | Decode error response |
| flash_sel_o | output | 1 | Flash select |
| flash_off_o | output | 18 | Flash offset |
| flash_rdata_i | input | 32 | Flash read data, same cycle as select |
| rom_sel_o | output | 1 | Boot ROM select |
| rom_off_o | output | 15 | Boot ROM offset |
| rom_rdata_i | input | 32 | Boot ROM read data |
| sram_sel_o | output | 1 | SRAM select |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_off_o | output | 17 | SRAM offset |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data |

## Verification
The hardest condition to create is a strap value that changes after reset release. The mapping must then ignore the pins, and that can only be seen indirectly. The bench resets under one strap value, moves the pins, and reads address zero and the control word to show the original mapping held. It also repeats resets under all four strap codes. A control-word write is followed back to back by an alias read, to show the new mapping applies from the very next transaction.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_FLASH = 3'd1,
    TGT_ROM   = 3'd2,
    TGT_SRAM  = 3'd3,
    TGT_CTRL  = 3'd4
  } tgt_e;

  localparam logic [1:0] MAP_FLASH     = 2'b00;
  localparam logic [1:0] MAP_ROM       = 2'b01;
  localparam logic [1:0] MAP_FLASH_ALT = 2'b10;
  localparam logic [1:0] MAP_SRAM      = 2'b11;
endpackage

// File: rtl/bm_reset_sync.sv
module bm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bm_map_reg.sv
module bm_map_reg (
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic [1:0] strap_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_val_i,
  output logic [1:0] map_o
);
  logic [1:0] map_q;
  logic [1:0] map_d;

  // Straps are sampled on every clock while reset is in effect, then held.
  always_comb begin
    if (!rst_sync_n)  map_d = strap_i;
    else if (wr_en_i) map_d = wr_val_i;
    else              map_d = map_q;
  end

  always_ff @(posedge clk) begin
    map_q <= map_d;
  end

  assign map_o = map_q;

  p_map_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en_i |=> map_q == $past(map_q));

  p_remap_load_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en_i |=> map_q == $past(wr_val_i));
endmodule

// File: rtl/bm_decode.sv
module bm_decode
  import bootmap_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter int          FLASH_AW   = 18,
  parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
  parameter int          ROM_AW     = 15,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_AW    = 17,
  parameter int          ALIAS_AW   = 16,
  parameter logic [31:0] CTRL_ADDR  = 32'h4000_0000
) (
  input  logic [31:0] addr_i,
  input  logic        we_i,
  input  logic [1:0]  map_i,
  output tgt_e        tgt_o
);
  logic in_alias;
  logic home_flash, home_rom, home_sram;
  logic fits_flash, fits_rom, fits_sram;
  tgt_e raw_tgt;

  assign in_alias   = (addr_i[31:ALIAS_AW] == '0);
  assign home_flash = (addr_i[31:FLASH_AW] == FLASH_BASE[31:FLASH_AW]);
  assign home_rom   = (addr_i[31:ROM_AW]   == ROM_BASE[31:ROM_AW]);
  assign home_sram  = (addr_i[31:SRAM_AW]  == SRAM_BASE[31:SRAM_AW]);
  // Whether an alias-window address lies inside the mirrored target.
  assign fits_flash = (addr_i[31:FLASH_AW] == '0);
  assign fits_rom   = (addr_i[31:ROM_AW]   == '0);
  assign fits_sram  = (addr_i[31:SRAM_AW]  == '0);

  always_comb begin
    raw_tgt = TGT_NONE;
    if (addr_i == CTRL_ADDR) begin
      raw_tgt = TGT_CTRL;
    end else if (in_alias) begin
      unique case (map_i)
        MAP_ROM:  raw_tgt = fits_rom  ? TGT_ROM  : TGT_NONE;
        MAP_SRAM: raw_tgt = fits_sram ? TGT_SRAM : TGT_NONE;
        default:  raw_tgt = fits_flash ? TGT_FLASH : TGT_NONE;
      endcase
    end else if (home_flash) begin
      raw_tgt = TGT_FLASH;
    end else if (home_rom) begin
      raw_tgt = TGT_ROM;
    end else if (home_sram) begin
      raw_tgt = TGT_SRAM;
    end
  end

  // Flash and boot ROM are read-only on this bus.
  always_comb begin
    tgt_o = raw_tgt;
    if (we_i && (raw_tgt == TGT_FLASH || raw_tgt == TGT_ROM)) tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/boot_alias_decoder.sv
module boot_alias_decoder
  import bootmap_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter int          FLASH_AW   = 18,
  parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
  parameter int          ROM_AW     = 15,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_AW    = 17,
  parameter int          ALIAS_AW   = 16,
  parameter logic [31:0] CTRL_ADDR  = 32'h4000_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          strap_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [31:0]         addr_i,
  input  logic [31:0]         wdata_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o,
  output logic                err_o,
  output logic                flash_sel_o,
  output logic [FLASH_AW-1:0] flash_off_o,
  input  logic [31:0]         flash_rdata_i,
  output logic                rom_sel_o,
  output logic [ROM_AW-1:0]   rom_off_o,
  input  logic [31:0]         rom_rdata_i,
  output logic                sram_sel_o,
  output logic                sram_we_o,
  output logic [SRAM_AW-1:0]  sram_off_o,
  output logic [31:0]         sram_wdata_o,
  input  logic [31:0]         sram_rdata_i
);
  localparam logic [31:0] RDATA_ZERO = 32'h0;

  logic       rst_sync_n;
  logic [1:0] map_cur;
  tgt_e       tgt;
  logic       ctrl_wr;

  logic        rvalid_q, rvalid_d;
  logic        err_q,    err_d;
  logic [31:0] rdata_q,  rdata_d;
  logic [31:0] sel_rdata;

  bm_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bm_decode #(
    .FLASH_BASE (FLASH_BASE), .FLASH_AW (FLASH_AW),
    .ROM_BASE   (ROM_BASE),   .ROM_AW   (ROM_AW),
    .SRAM_BASE  (SRAM_BASE),  .SRAM_AW  (SRAM_AW),
    .ALIAS_AW   (ALIAS_AW),   .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .map_i  (map_cur),
    .tgt_o  (tgt)
  );

  assign ctrl_wr = req_i && we_i && (tgt == TGT_CTRL);

  bm_map_reg u_map (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .strap_i    (strap_i),
    .wr_en_i    (ctrl_wr),
    .wr_val_i   (wdata_i[1:0]),
    .map_o      (map_cur)
  );

  // Target side: select plus low offset bits only.
  assign flash_sel_o  = req_i && (tgt == TGT_FLASH);
  assign rom_sel_o    = req_i && (tgt == TGT_ROM);
  assign sram_sel_o   = req_i && (tgt == TGT_SRAM);
  assign sram_we_o    = sram_sel_o && we_i;
  assign flash_off_o  = addr_i[FLASH_AW-1:0];
  assign rom_off_o    = addr_i[ROM_AW-1:0];
  assign sram_off_o   = addr_i[SRAM_AW-1:0];
  assign sram_wdata_o = wdata_i;

  always_comb begin
    unique case (tgt)
      TGT_FLASH: sel_rdata = flash_rdata_i;
      TGT_ROM:   sel_rdata = rom_rdata_i;
      TGT_SRAM:  sel_rdata = sram_rdata_i;
      TGT_CTRL:  sel_rdata = {30'b0, map_cur};
      default:   sel_rdata = RDATA_ZERO;
    endcase
  end

  // Response next-state.
  always_comb begin
    rvalid_d = req_i;
    err_d    = req_i && (tgt == TGT_NONE);
    rdata_d  = (req_i && !we_i) ? sel_rdata : RDATA_ZERO;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;

  p_one_sel_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({flash_sel_o, rom_sel_o, sram_sel_o}));

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> rvalid_o);

  p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !rvalid_o && !err_o);

  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> rdata_o == 32'h0);

  p_flash_home_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !we_i && addr_i[31:FLASH_AW] == FLASH_BASE[31:FLASH_AW])
      |-> flash_sel_o && flash_off_o == addr_i[FLASH_AW-1:0]);

  p_unmapped_err_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !flash_sel_o && !rom_sel_o && !sram_sel_o && addr_i != CTRL_ADDR)
      |=> err_o);

  p_rom_readonly_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && we_i && addr_i[31:ROM_AW] == ROM_BASE[31:ROM_AW]) |-> !rom_sel_o);
endmodule

// File: tb/boot_alias_decoder_test.sv
`timescale 1ns/1ps
module boot_alias_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        rvalid, err;
  logic [31:0] rdata;
  logic        f_sel, r_sel, s_sel, s_we;
  logic [17:0] f_off;
  logic [14:0] r_off;
  logic [16:0] s_off;
  logic [31:0] s_wdata;
  logic [31:0] f_rd, r_rd, s_rd;
  logic [31:0] sram_mem [0:63];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Behavioural targets: flash and ROM words are derived from the offset.
  assign f_rd = 32'hF000_0000 ^ {14'b0, f_off};
  assign r_rd = 32'hB000_0000 ^ {17'b0, r_off};
  assign s_rd = sram_mem[s_off[7:2]];

  always @(posedge clk) if (s_sel && s_we) sram_mem[s_off[7:2]] <= s_wdata;

  boot_alias_decoder uut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err),
    .flash_sel_o(f_sel), .flash_off_o(f_off), .flash_rdata_i(f_rd),
    .rom_sel_o(r_sel), .rom_off_o(r_off), .rom_rdata_i(r_rd),
    .sram_sel_o(s_sel), .sram_we_o(s_we), .sram_off_o(s_off),
    .sram_wdata_o(s_wdata), .sram_rdata_i(s_rd)
  );

  // {we, addr, wdata, exp_err, exp_data}, mapping code 2'b00
  localparam int NV = 15;
  localparam logic [97:0] VEC [0:NV-1] = '{
    {1'b0, 32'h0800_0000, 32'h0, 1'b0, 32'hF000_0000},  // R1
    {1'b0, 32'h0800_1234, 32'h0, 1'b0, 32'hF000_1234},  // R1
    {1'b0, 32'h0803_FFFC, 32'h0, 1'b0, 32'hF003_FFFC},  // R1 top word
    {1'b0, 32'h0804_0000, 32'h0, 1'b1, 32'h0},          // R6 past flash
    {1'b0, 32'h0000_0004, 32'h0, 1'b0, 32'hF000_0004},  // R3 alias flash
    {1'b0, 32'h0000_1234, 32'h0, 1'b0, 32'hF000_1234},  // R3
    {1'b0, 32'h0001_0000, 32'h0, 1'b1, 32'h0},          // R5 past window
    {1'b0, 32'h1FFF_0010, 32'h0, 1'b0, 32'hB000_0010},  // R2 ROM
    {1'b0, 32'h1FFF_8000, 32'h0, 1'b1, 32'h0},          // R6 past ROM
    {1'b0, 32'h2000_0008, 32'h0, 1'b0, 32'h5A00_0002},  // R2 SRAM
    {1'b0, 32'h2002_0000, 32'h0, 1'b1, 32'h0},          // R6 past SRAM
    {1'b0, 32'h4000_0000, 32'h0, 1'b0, 32'h0},          // R8 ctrl=00
    {1'b0, 32'h4000_0004, 32'h0, 1'b1, 32'h0},          // R8 neighbour
    {1'b1, 32'h0800_0000, 32'h1, 1'b1, 32'h0},          // R10 flash write
    {1'b1, 32'h1FFF_0000, 32'h1, 1'b1, 32'h0}           // R10 ROM write
  };

  logic [2:0] sels_seen;
  logic       got_v, got_e;
  logic [31:0] got_d;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1 sels_seen = {f_sel, r_sel, s_sel};
    @(negedge clk);
    got_v = rvalid; got_e = err; got_d = rdata;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) sram_mem[i] = 32'h5A00_0000 + i;
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0 && err == 1'b0 && rdata == 32'h0, "R9 reset state",
        {30'b0, rvalid, err}, 32'h0);
    do_reset(2'b00);

    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][97], VEC[i][96:65], VEC[i][64:33]);
      chk(got_v == 1'b1, "R9 valid after request", {31'b0, got_v}, 32'h1);
      chk(got_e == VEC[i][32], $sformatf("R6 err vec %0d", i), {31'b0, got_e}, {31'b0, VEC[i][32]});
      chk(got_d == VEC[i][31:0], $sformatf("R1 data vec %0d", i), got_d, VEC[i][31:0]);
      if (VEC[i][32])
        chk(sels_seen == 3'b000, $sformatf("R6 no select vec %0d", i), {29'b0, sels_seen}, 32'h0);
    end

    @(negedge clk);
    chk(rvalid == 1'b0, "R9 idle no valid", {31'b0, rvalid}, 32'h0);

    // R7: pins move after release, mapping stays flash
    strap = 2'b11;
    txn(1'b0, 32'h0, 32'h0);
    chk(got_d == 32'hF000_0000, "R7 alias after strap change", got_d, 32'hF000_0000);
    txn(1'b0, 32'h4000_0000, 32'h0);
    chk(got_d == 32'h0, "R7 ctrl after strap change", got_d, 32'h0);

    // R3/R4: ROM boot
    do_reset(2'b01);
    txn(1'b0, 32'h0, 32'h0);
    chk(got_d == 32'hB000_0000, "R4 ROM sp word", got_d, 32'hB000_0000);
    txn(1'b0, 32'h4, 32'h0);
    chk(got_d == 32'hB000_0004, "R4 ROM vector word", got_d, 32'hB000_0004);
    txn(1'b0, 32'h1FFF_0004, 32'h0);
    chk(got_d == 32'hB000_0004, "R4 ROM home word", got_d, 32'hB000_0004);
    txn(1'b0, 32'h0000_9000, 32'h0);
    chk(got_e == 1'b1 && got_d == 0, "R5 beyond ROM in window", {31'b0, got_e}, 32'h1);
    txn(1'b0, 32'h4000_0000, 32'h0);
    chk(got_d == 32'h1, "R8 ctrl from straps 01", got_d, 32'h1);
    txn(1'b0, 32'h0800_0010, 32'h0);
    chk(got_d == 32'hF000_0010, "R1 flash home under ROM map", got_d, 32'hF000_0010);

    // R3/R4: SRAM boot
    do_reset(2'b11);
    txn(1'b0, 32'h4, 32'h0);
    chk(got_d == 32'h5A00_0001, "R4 SRAM alias word", got_d, 32'h5A00_0001);
    txn(1'b0, 32'h2000_0004, 32'h0);
    chk(got_d == 32'h5A00_0001, "R4 SRAM home word", got_d, 32'h5A00_0001);
    txn(1'b0, 32'h4000_0000, 32'h0);
    chk(got_d == 32'h3, "R8 ctrl from straps 11", got_d, 32'h3);

    // R3: code 10 mirrors flash
    do_reset(2'b10);
    txn(1'b0, 32'h0, 32'h0);
    chk(got_d == 32'hF000_0000, "R3 code 10 flash", got_d, 32'hF000_0000);

    // R8: remap takes effect on the very next transaction
    txn(1'b1, 32'h4000_0000, 32'h3);
    chk(got_e == 1'b0, "R8 ctrl write ok", {31'b0, got_e}, 32'h0);
    txn(1'b0, 32'h0, 32'h0);
    chk(got_d == 32'h5A00_0000, "R8 SRAM after remap", got_d, 32'h5A00_0000);
    txn(1'b1, 32'h4000_0000, 32'h1);
    txn(1'b0, 32'h8, 32'h0);
    chk(got_d == 32'hB000_0008, "R8 ROM after remap", got_d, 32'hB000_0008);
    txn(1'b0, 32'h4000_0000, 32'h0);
    chk(got_d == 32'h1, "R8 ctrl readback", got_d, 32'h1);

    // R10: SRAM write passes and reads back, also through the alias
    txn(1'b1, 32'h2000_0010, 32'hDEAD_BEEF);
    chk(sels_seen == 3'b001 && got_e == 1'b0, "R10 SRAM write select", {29'b0, sels_seen}, 32'h1);
    txn(1'b0, 32'h2000_0010, 32'h0);
    chk(got_d == 32'hDEAD_BEEF, "R10 SRAM readback", got_d, 32'hDEAD_BEEF);
    txn(1'b1, 32'h4000_0000, 32'h3);
    txn(1'b0, 32'h10, 32'h0);
    chk(got_d == 32'hDEAD_BEEF, "R10 SRAM via alias", got_d, 32'hDEAD_BEEF);
    txn(1'b1, 32'h1FFF_0020, 32'h5);
    chk(sels_seen == 3'b000 && got_e == 1'b1, "R10 ROM write refused", {29'b0, sels_seen}, 32'h0);
    txn(1'b0, 32'h2002_0000, 32'h0);
    chk(got_e == 1'b1 && got_d == 0, "R2 SRAM bound", got_d, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule